// File: doc/BRIEF.md
# Two-Stage Pipelined Split Adder

This block adds two 16-bit operands and a carry-in. It splits the work into two 8-bit halves, so that each clock period holds only one 8-bit carry chain. In the first stage the low byte is summed straight from the inputs. Its sum and carry are registered, and the high bytes of both operands are registered beside them. In the second stage the high byte is summed, using the registered low carry as its carry-in. The high result is registered together with a delayed copy of the low result, so both halves of one transaction reach the outputs in the same cycle.

A new operand pair can be presented on every cycle. The full 17-bit result appears two rising edges after the operands were applied. An input qualifier travels down the pipe with the data and comes out as an output qualifier. The active-low asynchronous reset empties every stage at once.

The pipeline has no stall input. Its two named stages are the operand stage and the result stage, and data moves through them unconditionally on every rising edge.

Top module: `split_add_pipe`

## Requirements
- R1: While rst_n is low, `sum`, `cout` and `out_valid` are zero, and clearing does not wait for a clock edge.
- R2: When `a`, `b` and `cin` are applied before rising edge k, `sum` after rising edge k+1 equals a + b + cin as an unsigned 17-bit value.
- R3: `cout` equals the carry out of bit 15 of the same transaction, that is, bit 16 of the matching `sum`.
- R4: A carry out of bit 7 of the low byte reaches bit 8 of the result, including when it ripples through a high byte of all ones.
- R5: Operand pairs applied on consecutive cycles produce results on consecutive cycles, with no gaps and no mixing between neighbouring transactions.
- R6: `out_valid` after rising edge k+1 equals `in_valid` as applied before rising edge k.
- R7: The largest inputs, 0xFFFF + 0xFFFF + 1, give `sum` = 0x1FFFF with `cout` = 1.
- R8: A reset applied while transactions are in flight discards them. After release, the outputs stay at zero until operands applied after the release have passed both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifier for the operands applied this cycle |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry-in |
| sum | output | 17 | Result; bit 16 is the final carry |
| cout | output | 1 | Final carry-out, equal to sum[16] |
| out_valid | output | 1 | Qualifier delayed two cycles from in_valid |

## Verification
Four properties hold on every cycle once two edges have passed since reset: the full sum matches the operands from two cycles earlier, the high byte absorbs the low carry, the carry-out matches the 17-bit overflow, and the qualifier is delayed by exactly two edges. These checks use a separate behavioural sum, not the ripple slices. The bench scenarios cover what a property cannot reach: the asynchronous clear that happens between edges, a reset that drops transactions already in flight, and directed boundary operands mixed with seeded random back-to-back traffic.

// File: rtl/split_add_pkg.sv
package split_add_pkg;
    localparam int HALF_W = 8;
    localparam int FULL_W = 2 * HALF_W;
    localparam int SUM_W  = FULL_W + 1;

    // operand stage: low result plus high operands waiting for their carry
    typedef struct packed {
        logic              valid;
        logic              lo_carry;
        logic [HALF_W-1:0] lo_sum;
        logic [HALF_W-1:0] a_hi;
        logic [HALF_W-1:0] b_hi;
    } opnd_stage_t;

    // result stage: both halves aligned
    typedef struct packed {
        logic              valid;
        logic              hi_carry;
        logic [HALF_W-1:0] hi_sum;
        logic [HALF_W-1:0] lo_sum;
    } rslt_stage_t;
endpackage

// File: rtl/sa_slice.sv
module sa_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic prop;
            assign prop        = x[i] ^ y[i];
            assign s[i]        = prop ^ chain[i];
            assign chain[i+1]  = (x[i] & y[i]) | (prop & chain[i]);
        end
    endgenerate

    assign co = chain[W];
endmodule

// File: rtl/sa_stage_reg.sv
module sa_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/split_add_pipe.sv
module split_add_pipe
    import split_add_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [FULL_W-1:0] a,
    input  logic [FULL_W-1:0] b,
    input  logic              cin,
    output logic [SUM_W-1:0]  sum,
    output logic              cout,
    output logic              out_valid
);
    localparam int OPND_W = $bits(opnd_stage_t);
    localparam int RSLT_W = $bits(rslt_stage_t);

    opnd_stage_t opnd_d, opnd_q;
    rslt_stage_t rslt_d, rslt_q;

    logic [HALF_W-1:0] lo_sum_c, hi_sum_c;
    logic              lo_co_c, hi_co_c;

    // low byte, straight from the inputs
    sa_slice #(.W(HALF_W)) u_lo_slice (
        .x  (a[HALF_W-1:0]),
        .y  (b[HALF_W-1:0]),
        .ci (cin),
        .s  (lo_sum_c),
        .co (lo_co_c)
    );

    always_comb begin
        opnd_d.valid    = in_valid;
        opnd_d.lo_carry = lo_co_c;
        opnd_d.lo_sum   = lo_sum_c;
        opnd_d.a_hi     = a[FULL_W-1:HALF_W];
        opnd_d.b_hi     = b[FULL_W-1:HALF_W];
    end

    sa_stage_reg #(.W(OPND_W)) u_opnd_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (opnd_d),
        .q     (opnd_q)
    );

    // high byte, fed by the registered low carry
    sa_slice #(.W(HALF_W)) u_hi_slice (
        .x  (opnd_q.a_hi),
        .y  (opnd_q.b_hi),
        .ci (opnd_q.lo_carry),
        .s  (hi_sum_c),
        .co (hi_co_c)
    );

    always_comb begin
        rslt_d.valid    = opnd_q.valid;
        rslt_d.hi_carry = hi_co_c;
        rslt_d.hi_sum   = hi_sum_c;
        rslt_d.lo_sum   = opnd_q.lo_sum;
    end

    sa_stage_reg #(.W(RSLT_W)) u_rslt_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rslt_d),
        .q     (rslt_q)
    );

    always_comb begin
        sum       = {rslt_q.hi_carry, rslt_q.hi_sum, rslt_q.lo_sum};
        cout      = rslt_q.hi_carry;
        out_valid = rslt_q.valid;
    end

    // ---------------- checks ----------------
    logic [1:0] chk_age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_age <= 2'd0;
        end else if (chk_age != 2'd2) begin
            chk_age <= chk_age + 2'd1;
        end
    end

    logic [SUM_W-1:0]  ref_full;
    logic [HALF_W:0]   ref_lo;
    logic [HALF_W:0]   ref_hi_raw;
    always_comb begin
        ref_full   = {1'b0, a} + {1'b0, b} + SUM_W'(cin);
        ref_lo     = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + (HALF_W+1)'(cin);
        ref_hi_raw = {1'b0, a[FULL_W-1:HALF_W]} + {1'b0, b[FULL_W-1:HALF_W]};
    end

    // R2
    sum_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd2) |-> (sum == $past(ref_full, 2)));

    // R4
    hi_carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd2) |->
        (sum[SUM_W-1:HALF_W] == $past(ref_hi_raw, 2) + (HALF_W+1)'($past(ref_lo[HALF_W], 2))));

    // R3
    carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd2) |-> (cout == $past(ref_full[FULL_W], 2)));

    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_age == 2'd2) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/split_add_pipe_tb.sv
module split_add_pipe_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [16:0] sum;
    logic        cout;
    logic        out_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [16:0] h_sum [2];
    logic        h_val [2];
    string       h_tag [2];

    split_add_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a(a), .b(b), .cin(cin),
        .sum(sum), .cout(cout), .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 50000", cyc);
            report();
        end
    end

    task automatic cmp(string tag, logic [16:0] act, logic [16:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < 2; i++) begin
            h_sum[i] = '0; h_val[i] = 1'b0; h_tag[i] = "R8";
        end
    endtask

    // check the transaction from two cycles ago, then apply a new one
    task automatic step(logic [15:0] x, logic [15:0] y, logic c, logic v, string tag);
        @(negedge clk);
        cmp({h_tag[1], " sum (R2)"}, sum, h_sum[1]);
        cmp({h_tag[1], " cout (R3)"}, {16'd0, cout}, {16'd0, h_sum[1][16]});
        cmp({h_tag[1], " out_valid (R6)"}, {16'd0, out_valid}, {16'd0, h_val[1]});
        h_sum[1] = h_sum[0]; h_val[1] = h_val[0]; h_tag[1] = h_tag[0];
        h_sum[0] = ref_add(x, y, c); h_val[0] = v; h_tag[0] = tag;
        a = x; b = y; cin = c; in_valid = v;
    endtask

    initial begin
        void'($urandom(32'h51D3_0A7C));
        clear_hist();
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared during reset
        cmp("R1 reset sum", sum, 17'd0);
        cmp("R1 reset cout/valid", {15'd0, cout, out_valid}, 17'd0);
        rst_n = 1'b1;

        // R4: low carry crosses into the high byte
        step(16'h00FF, 16'h0001, 1'b0, 1'b1, "R4");
        step(16'h00FF, 16'h0000, 1'b1, 1'b1, "R4");
        step(16'hFF80, 16'h0080, 1'b0, 1'b1, "R4");
        // R7: extremes
        step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R7");
        step(16'hFFFF, 16'h0000, 1'b1, 1'b1, "R7");
        step(16'h0000, 16'h0000, 1'b0, 1'b0, "R6");
        step(16'h8000, 16'h8000, 1'b0, 1'b1, "R3");
        // R5: back-to-back random traffic
        for (int i = 0; i < 400; i++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "R5");
        end
        step(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R7");
        step(16'h1234, 16'h4321, 1'b1, 1'b1, "R5");

        // R8: reset with transactions in flight
        @(posedge clk);
        #2 rst_n = 1'b0;
        a = '0; b = '0; cin = 1'b0; in_valid = 1'b0;
        #1;
        cmp("R8 async clear sum", sum, 17'd0);
        cmp("R8 async clear valid", {16'd0, out_valid}, 17'd0);
        clear_hist();
        @(negedge clk);
        rst_n = 1'b1;
        step(16'hABCD, 16'h1111, 1'b1, 1'b1, "R8");
        step(16'h00FF, 16'hFF01, 1'b0, 1'b1, "R4");
        for (int i = 0; i < 50; i++) begin
            step(16'($urandom), 16'($urandom), 1'($urandom), 1'b1, "R5");
        end
        step(16'h0, 16'h0, 1'b0, 1'b0, "R6");
        step(16'h0, 16'h0, 1'b0, 1'b0, "R6");
        step(16'h0, 16'h0, 1'b0, 1'b0, "R6");
        report();
    end
endmodule